// File: doc/BRIEF.md
# Control-Block Driven DMA Channel

This block is one memory-to-memory DMA channel. It has a small 32-bit register interface and a master port that moves one word per access. Software does not program the source, destination or length directly. It stores a four-word descriptor in memory, writes the descriptor's address into a pointer register, and then sets the run bit in the control/status register. The channel reads the descriptor, copies the requested number of bytes one 32-bit word at a time, and then goes idle.

The descriptor holds four words. The first is a settings word that enables the interrupt and the address increments. The second is the source address, the third is the destination address, and the fourth is the byte count. Each source and destination address either advances by one word per copied word or stays fixed. A sticky completion flag is raised when interrupts are enabled, and it drives the channel's interrupt line until software clears it.

Top module: `cbdma_channel`

## Requirements
- R1: After reset, the control/status register (offset 0x0) reads 0, the pointer register reads 0, `irq` is low and no memory request is made.
- R2: Writing the control/status register with bit 0 (run) = 1 while idle starts a transfer. Bit 0 reads 1 from the next cycle on.
- R3: A transfer first reads four words from consecutive addresses pointer+0, +4, +8 and +12. These are the settings word (bit 0 interrupt enable, bit 4 destination increment, bit 8 source increment), the source address, the destination address and the byte count.
- R4: The channel then copies floor(count/4) words, ignoring count bits 1:0. Each word is one read followed by one write of the same data, and no access is made beyond that number. A count below 4 copies nothing.
- R5: For copied word k (from 0), the read address is source+4k when source increment is set and source otherwise. The write address follows the same rule with the destination address and the destination increment.
- R6: At most one memory access is outstanding. A request holds its address, direction and data until it is accepted. A read ends with `mem_rsp_valid`, and no request is issued while a read is pending. A write ends when it is accepted.
- R7: Run (bit 0) reads 0 from the cycle after the final write is accepted, or after the last descriptor word returns when nothing is copied. If interrupt enable was set, the flag (bit 2) becomes 1 at the same edge. Otherwise the flag is unchanged.
- R8: The flag stays set until the control/status register is written with bit 2 = 1. Writes with bit 2 = 0 leave it set. If completion and a clearing write fall on the same edge, the flag ends set.
- R9: A run write while a transfer is in progress is ignored, and so is a pointer write during a transfer. The running transfer makes exactly the accesses R3 to R5 give for the original descriptor.
- R10: `irq` equals bit 2 of the control/status register at all times.
- R11: The pointer register (offset 0x4) reads back the last value written. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted when high with valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the access |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| irq | output | 1 | Completion interrupt |

## Verification
Run is visible on the control/status read one cycle after the starting write. Each memory request appears the cycle after the previous access ends. The run bit falls, and the flag rises, one cycle after the final write is accepted (or after the final descriptor read returns when the count is below 4). A clearing write takes effect one cycle after it. The bench drives and compares at the falling clock edge. It works out in that same half-cycle whether a request will be accepted at the coming rising edge, and checks completion at the following falling edge. This keeps each comparison in the first cycle a result is due. The memory model varies its accept and response delays by cycle count, so these same-cycle checks are exercised under stalls.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;

    localparam int DW        = 32;
    localparam int OFS_CS    = 0;
    localparam int OFS_CBPTR = 4;

    localparam int CS_RUN_BIT  = 0;
    localparam int CS_FLAG_BIT = 2;

    localparam int SET_IEN_BIT  = 0;
    localparam int SET_DINC_BIT = 4;
    localparam int SET_SINC_BIT = 8;

    localparam int DESC_WORDS = 4;
    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ
    } eng_state_e;

endpackage

// File: rtl/cbdma_addr_step.sv
module cbdma_addr_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] cur,
    input  logic          en,
    output logic [AW-1:0] nxt
);
    // Advance by one word when enabled, otherwise hold the address.
    always_comb begin
        nxt = cur;
        if (en) begin
            nxt = cur + AW'(STEP);
        end
    end
endmodule

// File: rtl/cbdma_regs.sv
module cbdma_regs
    import cbdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic              done_irq,
    output logic              start,
    output logic [AW-1:0]     cb_ptr,
    output logic              flag
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          flag;
    } regs_t;

    regs_t q, d;
    logic  cs_hit;
    logic  ptr_hit;

    always_comb begin
        d       = q;
        cs_hit  = reg_wen && (reg_addr == REG_AW'(OFS_CS));
        ptr_hit = reg_wen && (reg_addr == REG_AW'(OFS_CBPTR));
        start   = cs_hit && reg_wdata[CS_RUN_BIT] && !busy;

        // Pointer only changes while idle so a running fetch is unaffected.
        if (ptr_hit && !busy) begin
            d.ptr = reg_wdata[AW-1:0];
        end

        // Completion outranks a clearing write on the same edge.
        if (done_irq) begin
            d.flag = 1'b1;
        end else if (cs_hit && reg_wdata[CS_FLAG_BIT]) begin
            d.flag = 1'b0;
        end

        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFS_CS)) begin
            reg_rdata[CS_RUN_BIT]  = busy;
            reg_rdata[CS_FLAG_BIT] = q.flag;
        end else if (reg_addr == REG_AW'(OFS_CBPTR)) begin
            reg_rdata[AW-1:0] = q.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cb_ptr = q.ptr;
    assign flag   = q.flag;

    // R2: an accepted start makes the engine busy on the next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8: the flag survives any cycle without a clearing write.
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !(cs_hit && reg_wdata[CS_FLAG_BIT])) |=> q.flag);

    // R7: the flag only rises on the edge the engine goes idle.
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> $fell(busy));
endmodule

// File: rtl/cbdma_engine.sv
module cbdma_engine
    import cbdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cb_ptr,
    output logic          busy,
    output logic          done_irq,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata
);
    localparam int WCNT_W = DW - 2;
    localparam int IDX_W  = $clog2(DESC_WORDS);

    typedef struct packed {
        eng_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [AW-1:0]     base;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic              ien;
        logic              sinc;
        logic              dinc;
        logic [WCNT_W-1:0] words;
        logic [DW-1:0]     data;
    } eng_t;

    eng_t          q, d;
    logic [AW-1:0] src_nxt;
    logic [AW-1:0] dst_nxt;
    logic          finish;

    cbdma_addr_step #(.AW(AW), .STEP(WORD_BYTES)) u_src_step (
        .cur (q.src),
        .en  (q.sinc),
        .nxt (src_nxt)
    );

    cbdma_addr_step #(.AW(AW), .STEP(WORD_BYTES)) u_dst_step (
        .cur (q.dst),
        .en  (q.dinc),
        .nxt (dst_nxt)
    );

    always_comb begin
        d             = q;
        finish        = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = q.data;

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_DESC_REQ;
                    d.base  = cb_ptr;
                    d.idx   = '0;
                end
            end
            ST_DESC_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.base + AW'({q.idx, 2'b00});
                if (mem_req_ready) begin
                    d.state = ST_DESC_WAIT;
                end
            end
            ST_DESC_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (q.idx)
                        2'd0: begin
                            d.ien  = mem_rsp_rdata[SET_IEN_BIT];
                            d.dinc = mem_rsp_rdata[SET_DINC_BIT];
                            d.sinc = mem_rsp_rdata[SET_SINC_BIT];
                        end
                        2'd1: d.src = mem_rsp_rdata[AW-1:0];
                        2'd2: d.dst = mem_rsp_rdata[AW-1:0];
                        default: d.words = mem_rsp_rdata[DW-1:2];
                    endcase
                    if (q.idx == IDX_W'(DESC_WORDS - 1)) begin
                        if (mem_rsp_rdata[DW-1:2] == '0) begin
                            d.state = ST_IDLE;
                            finish  = 1'b1;
                        end else begin
                            d.state = ST_RD_REQ;
                        end
                    end else begin
                        d.idx   = q.idx + IDX_W'(1);
                        d.state = ST_DESC_REQ;
                    end
                end
            end
            ST_RD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.src;
                if (mem_req_ready) begin
                    d.state = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    d.data  = mem_rsp_rdata;
                    d.state = ST_WR_REQ;
                end
            end
            ST_WR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = q.dst;
                if (mem_req_ready) begin
                    d.src   = src_nxt;
                    d.dst   = dst_nxt;
                    d.words = q.words - WCNT_W'(1);
                    if (q.words == WCNT_W'(1)) begin
                        d.state = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        d.state = ST_RD_REQ;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.state != ST_IDLE);
    assign done_irq = finish && q.ien;

    // R6: a request is held unchanged until it is accepted.
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    // R6: once a read is accepted nothing else is issued in the next cycle.
    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid);

    // R9: the register block never starts the engine while it is busy.
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.state == ST_IDLE));

    // R1: idle engine issues no memory traffic.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);
endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [AW-1:0]     mem_req_addr,
    output logic [DW-1:0]     mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_rdata,
    output logic              irq
);
    logic          busy;
    logic          done_irq;
    logic          start;
    logic [AW-1:0] cb_ptr;
    logic          flag;

    cbdma_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done_irq  (done_irq),
        .start     (start),
        .cb_ptr    (cb_ptr),
        .flag      (flag)
    );

    cbdma_engine #(.AW(AW)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cb_ptr        (cb_ptr),
        .busy          (busy),
        .done_irq      (done_irq),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata)
    );

    assign irq = flag;
endmodule

// File: tb/cbdma_channel_tb.sv
module cbdma_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        irq;

    always #5 clk = ~clk;

    cbdma_channel u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wen       (reg_wen),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .irq           (irq)
    );

    localparam logic [31:0] CB_A  = 32'h0000_0040;
    localparam logic [31:0] SRC_A = 32'h0000_0100;
    localparam logic [31:0] DST_A = 32'h0000_0400;
    localparam logic [31:0] SENT  = 32'hDEAD_0000;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A00_0000 ^ (a * 32'h0001_0003);
    endfunction

    // Expected transfer, written by the main process only.
    logic [31:0] e_src, e_dst, e_len, e_info;
    int          e_n = 0;
    bit          e_sinc, e_dinc, e_ien;
    int          go_cnt = 0;

    // Main-process counters.
    int n_chk = 0;
    int n_fail = 0;

    // Monitor-owned state.
    int          m_chk = 0;
    int          m_fail = 0;
    int          cyc = 0;
    int          e_idx = 0;
    int          seen_go = 0;
    int          done_cnt = 0;
    int          last_reqs = 0;
    bit          armed = 0;
    bit          fin_next = 0;
    bit          rsp_pend = 0;
    bit          rsp_fin = 0;
    int          rsp_cnt = 0;
    logic [31:0] rsp_data = '0;
    logic [31:0] dmem [0:15];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory model and request checker, all at the falling edge.
    always @(negedge clk) begin
        int          j;
        int          k;
        bit          ew;
        logic [31:0] ea;
        if (!rst_n) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
        end else begin
            cyc++;
            if (fin_next) begin
                fin_next = 0;
                mchk(reg_rdata[0] == 1'b0, "R7 run bit cleared after completion",
                     {31'b0, reg_rdata[0]}, 32'd0);
                mchk(irq == e_ien, "R7 flag after completion", {31'b0, irq},
                     {31'b0, e_ien});
                done_cnt++;
            end
            if (reg_addr == 4'h0) begin
                mchk(irq == reg_rdata[2], "R10 irq equals flag bit", {31'b0, irq},
                     {31'b0, reg_rdata[2]});
            end
            if (go_cnt != seen_go) begin
                seen_go = go_cnt;
                armed   = 1;
                e_idx   = 0;
                for (int i = 0; i < 16; i++) dmem[i] = SENT ^ 32'(i);
            end
            mem_rsp_valid = 1'b0;
            if (rsp_pend) begin
                mchk(!mem_req_valid, "R6 request while read pending",
                     {31'b0, mem_req_valid}, 32'd0);
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rsp_data;
                    rsp_pend      = 0;
                    if (rsp_fin) begin
                        mchk(reg_rdata[0] == 1'b1, "R7 run bit before completion",
                             {31'b0, reg_rdata[0]}, 32'd1);
                        fin_next  = 1;
                        armed     = 0;
                        last_reqs = e_idx;
                    end
                end else begin
                    rsp_cnt--;
                end
            end
            mem_req_ready = ((cyc % 3) != 1);
            if (mem_req_valid && mem_req_ready) begin
                if (!armed || e_idx >= 4 + 2 * e_n) begin
                    mchk(0, "R9 unexpected request", mem_req_addr, 32'hFFFF_FFFF);
                end else begin
                    k = 0;
                    if (e_idx < 4) begin
                        ew = 0;
                        ea = CB_A + 32'(4 * e_idx);
                        mchk(mem_req_write == ew && mem_req_addr == ea,
                             "R3 descriptor read address", mem_req_addr, ea);
                    end else begin
                        j  = e_idx - 4;
                        k  = j / 2;
                        ew = (j % 2) == 1;
                        ea = ew ? (e_dst + (e_dinc ? 32'(4 * k) : 32'd0))
                                : (e_src + (e_sinc ? 32'(4 * k) : 32'd0));
                        mchk(mem_req_write == ew && mem_req_addr == ea,
                             "R5 copy address and direction",
                             {mem_req_addr[31:1], mem_req_write}, {ea[31:1], ew});
                    end
                    if (!ew) begin
                        rsp_pend = 1;
                        rsp_cnt  = cyc % 3;
                        rsp_fin  = (e_idx == 3) && (e_n == 0);
                        case (e_idx)
                            0: rsp_data = e_info;
                            1: rsp_data = e_src;
                            2: rsp_data = e_dst;
                            3: rsp_data = e_len;
                            default: rsp_data = pat(ea);
                        endcase
                    end else begin
                        ea = e_src + (e_sinc ? 32'(4 * k) : 32'd0);
                        mchk(mem_req_wdata == pat(ea), "R4 written data",
                             mem_req_wdata, pat(ea));
                        dmem[e_dinc ? k : 0] = mem_req_wdata;
                        if (k == e_n - 1) begin
                            mchk(reg_rdata[0] == 1'b1, "R7 run bit before completion",
                                 {31'b0, reg_rdata[0]}, 32'd1);
                            fin_next  = 1;
                            armed     = 0;
                            last_reqs = e_idx + 1;
                        end
                    end
                    e_idx++;
                end
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        reg_wen = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_wen = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
    endtask

    // mode 0: plain, 1: restart and pointer pokes mid-run, 2: clear held all along
    task automatic run_xfer(input int n, input int lowb, input bit si, input bit di,
                            input bit ie, input int mode);
        int d0;
        int t;
        int u;
        wr_reg(4'h0, 32'h4);
        wr_reg(4'h4, CB_A);
        e_n    = n;
        e_sinc = si;
        e_dinc = di;
        e_ien  = ie;
        e_src  = SRC_A;
        e_dst  = DST_A;
        e_len  = 32'(4 * n + lowb);
        e_info = (32'(si) << 8) | (32'(di) << 4) | 32'(ie);
        d0     = done_cnt;
        go_cnt++;
        @(negedge clk); #1;
        reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1;
        @(negedge clk); #1;
        reg_wen = 1'b0; reg_wdata = '0;
        chk(reg_rdata[0] == 1'b1, "R2 run bit set after start", {31'b0, reg_rdata[0]}, 32'd1);
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk); #1;
            t++;
            if (done_cnt != d0) break;
            if (mode == 1 && t == 3) begin
                reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h1;
            end else if (mode == 1 && t == 4) begin
                reg_addr = 4'h4; reg_wdata = 32'h80;
            end else if (mode == 1 && t == 5) begin
                reg_wen = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
            end else if (mode == 2) begin
                reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h4;
            end
        end
        reg_wen = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
        chk(done_cnt != d0, "R7 transfer completion seen", 32'(t), 32'd3000);
        chk(last_reqs == 4 + 2 * n, "R4 number of accesses", 32'(last_reqs), 32'(4 + 2 * n));
        u = di ? n : ((n > 0) ? 1 : 0);
        chk(dmem[u] == (SENT ^ 32'(u)), "R4 no write past the last word", dmem[u],
            SENT ^ 32'(u));
        if (n > 0 && !di) begin
            chk(dmem[0] == pat(SRC_A + (si ? 32'(4 * (n - 1)) : 32'd0)),
                "R5 fixed destination holds last word", dmem[0],
                pat(SRC_A + (si ? 32'(4 * (n - 1)) : 32'd0)));
        end
        if (mode == 1) begin
            reg_addr = 4'h4; #1;
            chk(reg_rdata == CB_A, "R9 pointer write ignored while running", reg_rdata, CB_A);
            reg_addr = 4'h0;
        end
        if (mode == 2) begin
            chk(irq == 1'b1, "R8 set wins over same-edge clear", {31'b0, irq}, 32'd1);
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(reg_rdata == 32'd0, "R1 control/status after reset", reg_rdata, 32'd0);
        chk(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'd0);
        chk(mem_req_valid == 1'b0, "R1 no request after reset", {31'b0, mem_req_valid}, 32'd0);
        reg_addr = 4'h4; #1;
        chk(reg_rdata == 32'd0, "R1 pointer after reset", reg_rdata, 32'd0);
        reg_addr = 4'h8; #1;
        chk(reg_rdata == 32'd0, "R11 unused offset reads zero", reg_rdata, 32'd0);
        reg_addr = 4'h0;
        wr_reg(4'h4, 32'h1234_5670);
        reg_addr = 4'h4; #1;
        chk(reg_rdata == 32'h1234_5670, "R11 pointer readback", reg_rdata, 32'h1234_5670);
        reg_addr = 4'hC; #1;
        chk(reg_rdata == 32'd0, "R11 unused offset reads zero", reg_rdata, 32'd0);
        reg_addr = 4'h0;

        // Sweep word counts and increment modes.
        for (int n = 0; n <= 5; n++) begin
            for (int m = 0; m < 4; m++) begin
                run_xfer(n, n % 4, m[1], m[0], ((n + m) % 2) == 1, 0);
            end
        end

        // Flag stickiness and clearing.
        run_xfer(2, 3, 1'b1, 1'b1, 1'b1, 0);
        chk(irq == 1'b1, "R8 flag held after completion", {31'b0, irq}, 32'd1);
        wr_reg(4'h0, 32'h0);
        chk(irq == 1'b1 && reg_rdata[2], "R8 write of zero keeps flag",
            {31'b0, irq}, 32'd1);
        wr_reg(4'h0, 32'h4);
        chk(irq == 1'b0 && !reg_rdata[2], "R8 write of one clears flag",
            {31'b0, irq}, 32'd0);

        run_xfer(5, 0, 1'b1, 1'b1, 1'b1, 1);
        run_xfer(2, 1, 1'b1, 1'b0, 1'b1, 2);
        wr_reg(4'h0, 32'h4);
        chk(irq == 1'b0, "R8 clear after held-clear run", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        bit wd;
        wd = 0;
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

endmodule